// File: doc/BRIEF.md
# Carry-less Polynomial Multiplier and Squarer

This block multiplies two polynomials with coefficients in GF(2). Each operand is an N-bit vector whose bit i is the coefficient of x^i. Coefficients are multiplied with AND and summed with XOR, so no carry ever crosses from one bit position to the next. The result is the unreduced product of 2N-1 bits. The block does not reduce the result modulo a field polynomial.

A mode input selects a squaring path. In that path the second operand is ignored, and operand A is spread out so that its bits land on the even positions of the result. All odd positions are zero. No partial products are formed, because the cross terms of a square cancel in pairs.

The chosen result is captured in a single output register when an input-valid strobe is high. A matching output-valid strobe follows one cycle later.

Top module: `gf2_poly_mult`

## Requirements
- R1: While reset is high at a rising clock edge, `product` becomes 0 and `validOut` becomes 0.
- R2: With `squareMode`=0, `product` is the XOR of `opA` shifted left by i, taken for every set bit i of `opB`. Bit k is the XOR of all `opA[i] & opB[j]` with i+j=k, and no carries are produced.
- R3: With `squareMode`=1, `product[2i]` equals `opA[i]` for every i in 0..N-1, and every odd bit of `product` is 0.
- R4: With `squareMode`=1, the value of `opB` has no effect on `product`.
- R5: `validOut` equals the value `validIn` had at the previous rising edge, one cycle of latency.
- R6: When `validIn` is low, `product` holds its previous value whatever the operands and mode do.
- R7: In multiply mode, a zero `opB` gives a zero product. An `opB` of 1 gives `opA` zero-extended to 2N-1 bits.
- R8: For every one of the 2^N values of `opA`, the square result equals the multiply result with `opB`=`opA`.
- R9: When reset and `validIn` are high in the same cycle, reset wins: `product` and `validOut` are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| validIn | input | 1 | Capture strobe for the operands |
| squareMode | input | 1 | 1 selects the squaring path, 0 selects the general multiply path |
| opA | input | N | First operand polynomial, bit i is the coefficient of x^i |
| opB | input | N | Second operand polynomial, ignored when squaring |
| validOut | output | 1 | Result-valid strobe, one cycle after validIn |
| product | output | 2N-1 | Registered carry-less product |

## Verification
Two functions can meet in one cycle: a capture strobe and a synchronous reset. The bench provokes this by raising `validIn` with fresh non-zero operands in the same cycle as `rst`. It then judges that both the product and the valid strobe come out cleared, not loaded. A second overlap comes from switching between the square and multiply paths on back-to-back captures of the same operand. The two results of each such pair are compared against each other and against the interleave pattern, across every operand value.

// File: rtl/gf2mul_pkg.sv
package gf2mul_pkg;

  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic loadEn;     // capture the selected result this edge
    logic squareSel;  // 1: interleave path, 0: XOR-of-shifts path
  } ctrlStrobes_t;

endpackage

// File: rtl/gf2mul_ctrl.sv
module gf2mul_ctrl
  import gf2mul_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         validIn,
  input  logic         squareMode,
  output ctrlStrobes_t strb,
  output logic         validOut
);

  always_comb begin
    strb.loadEn    = validIn;
    strb.squareSel = squareMode;
  end

  always_ff @(posedge clk) begin
    if (rst) validOut <= 1'b0;
    else     validOut <= validIn;
  end

  // R5
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (validOut == $past(validIn)));

endmodule

// File: rtl/gf2mul_datapath.sv
module gf2mul_datapath
  import gf2mul_pkg::*;
#(
  parameter int N = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  ctrlStrobes_t        strb,
  input  logic [N-1:0]        opA,
  input  logic [N-1:0]        opB,
  output logic [2*N-2:0]      product
);

  localparam int PROD_W = 2 * N - 1;

  // ---------------- general path: XOR of shifted copies ----------------
  logic [PROD_W-1:0] aExt;
  logic [PROD_W-1:0] rowVec [N];
  logic [PROD_W-1:0] accVec [N+1];

  assign aExt      = PROD_W'(opA);
  assign accVec[0] = '0;

  for (genvar i = 0; i < N; i++) begin : g_rows
    assign rowVec[i]   = opB[i] ? (aExt << i) : '0;
    assign accVec[i+1] = accVec[i] ^ rowVec[i];
  end

  logic [PROD_W-1:0] mulVec;
  assign mulVec = accVec[N];

  // ---------------- square path: interleave with zeros -----------------
  logic [PROD_W-1:0] sqVec;

  for (genvar i = 0; i < N; i++) begin : g_even
    assign sqVec[2*i] = opA[i];
  end
  for (genvar i = 0; i + 1 < N; i++) begin : g_odd
    assign sqVec[2*i+1] = 1'b0;
  end

  // ---------------- select and register --------------------------------
  logic [PROD_W-1:0] nextProd;
  assign nextProd = strb.squareSel ? sqVec : mulVec;

  always_ff @(posedge clk) begin
    if (rst)              product <= '0;
    else if (strb.loadEn) product <= nextProd;
  end

  // odd-position mask for the square check
  function automatic logic [PROD_W-1:0] oddMask();
    logic [PROD_W-1:0] m;
    m = '0;
    for (int k = 1; k < PROD_W; k += 2) m[k] = 1'b1;
    return m;
  endfunction

  // R6
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && !strb.loadEn) |=> $stable(product));

  // R3
  square_odd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && strb.loadEn && strb.squareSel) |=> ((product & oddMask()) == '0));

  // R7
  zero_operand_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && strb.loadEn && !strb.squareSel && opB == '0) |=> (product == '0));

  // R7
  unit_operand_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && strb.loadEn && !strb.squareSel && opB == N'(1))
      |=> (product == PROD_W'($past(opA))));

endmodule

// File: rtl/gf2_poly_mult.sv
module gf2_poly_mult
  import gf2mul_pkg::*;
#(
  parameter int N = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           validIn,
  input  logic           squareMode,
  input  logic [N-1:0]   opA,
  input  logic [N-1:0]   opB,
  output logic           validOut,
  output logic [2*N-2:0] product
);

  ctrlStrobes_t strb;

  gf2mul_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .validIn    (validIn),
    .squareMode (squareMode),
    .strb       (strb),
    .validOut   (validOut)
  );

  gf2mul_datapath #(.N(N)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .opA     (opA),
    .opB     (opB),
    .product (product)
  );

endmodule

// File: tb/gf2_poly_mult_bench.sv
module gf2_poly_mult_bench;

  localparam int N  = 5;
  localparam int PW = 2 * N - 1;
  localparam int NV = 9;

  // hand-derived vectors: a, b, mode, expected product
  localparam logic [N-1:0]  TA [NV] = '{5'h00, 5'h15, 5'h03, 5'h1F, 5'h1F, 5'h07, 5'h10, 5'h0B, 5'h12};
  localparam logic [N-1:0]  TB [NV] = '{5'h1F, 5'h01, 5'h03, 5'h1F, 5'h00, 5'h05, 5'h10, 5'h06, 5'h1F};
  localparam logic          TM [NV] = '{1'b0,  1'b0,  1'b0,  1'b0,  1'b1,  1'b0,  1'b0,  1'b0,  1'b1};
  localparam logic [PW-1:0] TE [NV] = '{9'h000, 9'h015, 9'h005, 9'h155, 9'h155, 9'h01B, 9'h100, 9'h03A, 9'h104};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic validIn = 1'b0;
  logic squareMode = 1'b0;
  logic [N-1:0] opA = '0;
  logic [N-1:0] opB = '0;
  logic validOut;
  logic [PW-1:0] product;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  gf2_poly_mult #(.N(N)) u_gf2_poly_mult (
    .clk(clk), .rst(rst), .validIn(validIn), .squareMode(squareMode),
    .opA(opA), .opB(opB), .validOut(validOut), .product(product)
  );

  task automatic check(input string req, input logic [PW-1:0] got, input logic [PW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one capture: inputs set after a falling edge, result read at the next falling edge
  task automatic capture(input logic [N-1:0] a, input logic [N-1:0] b, input logic m);
    @(negedge clk);
    opA = a; opB = b; squareMode = m; validIn = 1'b1;
    @(negedge clk);
    validIn = 1'b0;
  endtask

  function automatic logic [PW-1:0] spread(input logic [N-1:0] a);
    logic [PW-1:0] r = '0;
    for (int i = 0; i < N; i++) r[2*i] = a[i];
    return r;
  endfunction

  initial begin
    logic [PW-1:0] mulRes;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 product", product, '0);
    check("R1 validOut", PW'(validOut), '0);
    rst = 1'b0;

    // table walk: R2 general, R3/R4 square, R7 zero and unit operands
    for (int v = 0; v < NV; v++) begin
      capture(TA[v], TB[v], TM[v]);
      check(TM[v] ? "R3/R4 table" : "R2/R7 table", product, TE[v]);
      check("R5 validOut high", PW'(validOut), PW'(1));
    end

    // R5: strobe drops one cycle after validIn drops
    @(negedge clk);
    check("R5 validOut low", PW'(validOut), '0);

    // R6: operand and mode changes with validIn low leave product alone
    opA = 5'h1F; opB = 5'h1F; squareMode = 1'b0;
    @(negedge clk);
    squareMode = 1'b1;
    @(negedge clk);
    check("R6 hold", product, 9'h104);

    // R4: same opA, two different opB values in square mode
    capture(5'h09, 5'h00, 1'b1);
    check("R4 b=00", product, 9'h041);
    capture(5'h09, 5'h1E, 1'b1);
    check("R4 b=1E", product, 9'h041);

    // R9: reset and capture in the same cycle
    @(negedge clk);
    opA = 5'h1F; opB = 5'h1F; squareMode = 1'b0; validIn = 1'b1; rst = 1'b1;
    @(negedge clk);
    validIn = 1'b0; rst = 1'b0;
    check("R9 product", product, '0);
    check("R9 validOut", PW'(validOut), '0);

    // R8: exhaustive square vs multiply-by-self
    for (int a = 0; a < (1 << N); a++) begin
      capture(N'(a), N'(a), 1'b0);
      mulRes = product;
      capture(N'(a), ~N'(a), 1'b1);
      check("R8 square==mul", product, mulRes);
      check("R3 interleave", product, spread(N'(a)));
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule